// File: doc/BRIEF.md
# Event performance monitor counter bank

This block counts hardware events for performance analysis. A one-hot vector of event lines comes in from the monitored logic. A small set of 32-bit event counters and one 64-bit cycle counter accumulate those events under software control. Software programs and reads the bank through a simple word-addressed register bus, which has an address, a write strobe, write data and registered read data.

Each event counter has its own selector, so it can count any one of the incoming event lines, count every cycle, or count nothing. The cycle counter can run freely. It can also be limited to a window that opens on one chosen event and closes on another. Every counter keeps a sticky overflow flag, which is set when the counter wraps. The interrupt output is raised when any overflow flag is set and that counter's interrupt mask bit is also set. The enable mask, the overflow flags and the interrupt mask each have their own write-1-to-set and write-1-to-clear registers. Software can therefore change single bits without a read-modify-write.

Register map (word addresses):
- 0x00 control
- 0x01 enable set, 0x02 enable clear
- 0x03 overflow set, 0x04 overflow clear
- 0x05 interrupt set, 0x06 interrupt clear
- 0x07 cycle count low word, 0x08 cycle count high word
- 0x09 cycle window configuration
- 0x10+n counter n value
- 0x18+n counter n selector

Top module: `perfmon_bank`

## Requirements
- R1: While rst is high and on the cycle after it, every register reads 0 and irq_o is low.
- R2: Control bit 0 is the global enable and reads back. A write with bit 1 set clears all event counters. A write with bit 2 set clears the cycle counter. Bits 1 and 2 read as 0.
- R3: An event counter adds exactly one on a clock edge only when three conditions hold in that cycle: the global enable is set, its own enable bit is set, and its selected event is high. Otherwise it holds its value.
- R4: Selector value 0 counts nothing and value 1 counts every cycle. A value n of 2 or more counts evt_i[n], so evt_i bits 0 and 1 never affect any counter.
- R5: In every mask register, bit n (for n below NUM_CNT) stands for event counter n and bit 31 stands for the cycle counter. Writing 1s to enable-set (0x01) turns those bits on. Writing 1s to enable-clear (0x02) turns them off. Zero bits have no effect. Both addresses read the current enable mask.
- R6: A counter that wraps from all ones to zero sets its sticky overflow flag. Writing 1s to 0x04 clears flags and writing 1s to 0x03 sets them. If a wrap and a clear of the same flag happen in one cycle, the flag ends set. Both addresses read the flags.
- R7: The interrupt mask is changed through 0x05 (set) and 0x06 (clear), and both addresses read it back. irq_o is high in the cycle after some counter has both its overflow flag and its mask bit set.
- R8: Writing a counter's value register loads that value, and the write takes priority over an increment in the same cycle. The cycle counter's low word (0x07) and high word (0x08) are loaded separately.
- R9: The configuration register holds the start event in bits [9:0] and the stop event in bits [25:16]. With a start event of 0 the enabled cycle counter counts every cycle. Otherwise a start event in cycle t makes it count from cycle t+1 on. A stop event in cycle t makes cycle t the last counted cycle. When start and stop fire in the same cycle, stop wins.
- R10: bus_rdata_o shows, one cycle after the address, the register contents from before any write in that cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 5 | Word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data |
| evt_i | input | 2**EVT_W | One-hot event lines |
| irq_o | output | 1 | Overflow interrupt, registered |

## Verification
The bench builds the bank with NUM_CNT=4 and EVT_W=4. With 16 event lines, random event patterns regularly hit every selector value, including the top index and the two reserved values. The counters stay at their full width of 32 and 64 bits. Wraps are therefore reached by preloading values just below all ones rather than by counting up, which also covers the case where a wrap coincides with a write-1-to-clear.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 5'h01;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 5'h02;
  localparam logic [ADDR_W-1:0] A_OV_SET  = 5'h03;
  localparam logic [ADDR_W-1:0] A_OV_CLR  = 5'h04;
  localparam logic [ADDR_W-1:0] A_IE_SET  = 5'h05;
  localparam logic [ADDR_W-1:0] A_IE_CLR  = 5'h06;
  localparam logic [ADDR_W-1:0] A_CYC_LO  = 5'h07;
  localparam logic [ADDR_W-1:0] A_CYC_HI  = 5'h08;
  localparam logic [ADDR_W-1:0] A_CYC_CFG = 5'h09;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 5'h10;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 5'h18;

  // control bit positions
  localparam int unsigned CTRL_EN      = 0;
  localparam int unsigned CTRL_EVT_CLR = 1;
  localparam int unsigned CTRL_CYC_CLR = 2;

  // window configuration field positions
  localparam int unsigned START_LSB = 0;
  localparam int unsigned STOP_LSB  = 16;
endpackage

// File: rtl/perfmon_evt_pick.sv
module perfmon_evt_pick #(
  parameter int unsigned EVT_W = 10
) (
  input  logic [EVT_W-1:0]        sel_i,
  input  logic [(1<<EVT_W)-1:0]   evt_i,
  output logic                    hit_o
);
  always_comb begin
    if (sel_i == '0)                 hit_o = 1'b0;
    else if (sel_i == EVT_W'(1))     hit_o = 1'b1;
    else                             hit_o = evt_i[sel_i];
  end
endmodule

// File: rtl/perfmon_evt_cnt.sv
module perfmon_evt_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~load_i & ~clr_i & (&cnt_q);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(inc_i || load_i || clr_i) |=> $stable(cnt_o));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_o == $past(load_val_i));
endmodule

// File: rtl/perfmon_cyc_cnt.sv
module perfmon_cyc_cnt #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic                free_run_i,
  input  logic                start_hit_i,
  input  logic                stop_hit_i,
  input  logic                clr_i,
  input  logic                ld_lo_i,
  input  logic                ld_hi_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [2*HALF_W-1:0] cnt_o,
  output logic                wrap_o
);
  logic [2*HALF_W-1:0] cnt_q;
  logic                run_q;
  logic                count;

  always_ff @(posedge clk) begin
    if (rst)              run_q <= 1'b0;
    else if (stop_hit_i)  run_q <= 1'b0;
    else if (start_hit_i) run_q <= 1'b1;
  end

  assign count = en_i & (free_run_i | run_q);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (ld_lo_i) cnt_q[HALF_W-1:0] <= wdata_i;
    else if (ld_hi_i) cnt_q[2*HALF_W-1:HALF_W] <= wdata_i;
    else if (clr_i)   cnt_q <= '0;
    else if (count)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = count & ~ld_lo_i & ~ld_hi_i & ~clr_i & (&cnt_q);

  // R9
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (start_hit_i && stop_hit_i) |=> !run_q);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !ld_lo_i && !ld_hi_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/perfmon_bank.sv
module perfmon_bank
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned EVT_W   = 10,
  parameter int unsigned DW      = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic                    bus_we_i,
  input  logic [DW-1:0]           bus_wdata_i,
  output logic [DW-1:0]           bus_rdata_o,
  input  logic [(1<<EVT_W)-1:0]   evt_i,
  output logic                    irq_o
);
  localparam int unsigned NUM_EVT = 1 << EVT_W;
  localparam int unsigned CYC_W   = 2 * DW;
  localparam int unsigned LIVE_W  = NUM_CNT + 1;
  localparam int unsigned CYC_IDX = NUM_CNT;

  function automatic logic [LIVE_W-1:0] to_live(input logic [DW-1:0] w);
    return {w[DW-1], w[NUM_CNT-1:0]};
  endfunction

  function automatic logic [DW-1:0] to_bus(input logic [LIVE_W-1:0] l);
    logic [DW-1:0] r;
    r = '0;
    r[DW-1] = l[CYC_IDX];
    r[NUM_CNT-1:0] = l[NUM_CNT-1:0];
    return r;
  endfunction

  logic                 glob_q;
  logic [LIVE_W-1:0]    en_q, ovf_q, ien_q, wrap_vec, wmask;
  logic [EVT_W-1:0]     start_q, stop_q;
  logic [DW-1:0]        rdata_q, rd_nxt;
  logic                 irq_q;
  logic [NUM_CNT-1:0][DW-1:0]    cnt_all;
  logic [NUM_CNT-1:0][EVT_W-1:0] sel_all;
  logic [CYC_W-1:0]     cyc_cnt;
  logic                 start_hit, stop_hit;
  logic                 we_ctrl, evt_clr, cyc_clr;

  assign wmask   = to_live(bus_wdata_i);
  assign we_ctrl = bus_we_i && (bus_addr_i == A_CTRL);
  assign evt_clr = we_ctrl && bus_wdata_i[CTRL_EVT_CLR];
  assign cyc_clr = we_ctrl && bus_wdata_i[CTRL_CYC_CLR];

  // control, masks, window config, read and interrupt registers
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_q  <= 1'b0;
      en_q    <= '0;
      ovf_q   <= '0;
      ien_q   <= '0;
      start_q <= '0;
      stop_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (we_ctrl) glob_q <= bus_wdata_i[CTRL_EN];
      if (bus_we_i && bus_addr_i == A_EN_SET)      en_q <= en_q | wmask;
      else if (bus_we_i && bus_addr_i == A_EN_CLR) en_q <= en_q & ~wmask;
      if (bus_we_i && bus_addr_i == A_IE_SET)      ien_q <= ien_q | wmask;
      else if (bus_we_i && bus_addr_i == A_IE_CLR) ien_q <= ien_q & ~wmask;
      ovf_q <= (ovf_q & ~((bus_we_i && bus_addr_i == A_OV_CLR) ? wmask : '0))
             | ((bus_we_i && bus_addr_i == A_OV_SET) ? wmask : '0)
             | wrap_vec;
      if (bus_we_i && bus_addr_i == A_CYC_CFG) begin
        start_q <= bus_wdata_i[START_LSB +: EVT_W];
        stop_q  <= bus_wdata_i[STOP_LSB +: EVT_W];
      end
      rdata_q <= rd_nxt;
      irq_q   <= |(ovf_q & ien_q);
    end
  end

  // event counters
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
    logic [EVT_W-1:0] sel_r;
    logic             hit;

    always_ff @(posedge clk) begin
      if (rst) sel_r <= '0;
      else if (bus_we_i && bus_addr_i == ADDR_W'(A_SEL_BASE + i))
        sel_r <= bus_wdata_i[EVT_W-1:0];
    end

    perfmon_evt_pick #(.EVT_W(EVT_W)) u_pick (
      .sel_i (sel_r),
      .evt_i (evt_i),
      .hit_o (hit)
    );

    perfmon_evt_cnt #(.CNT_W(DW)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .load_i     (bus_we_i && bus_addr_i == ADDR_W'(A_CNT_BASE + i)),
      .load_val_i (bus_wdata_i),
      .clr_i      (evt_clr),
      .inc_i      (glob_q & en_q[i] & hit),
      .cnt_o      (cnt_all[i]),
      .wrap_o     (wrap_vec[i])
    );

    assign sel_all[i] = sel_r;
  end

  // cycle counter with start/stop window
  perfmon_evt_pick #(.EVT_W(EVT_W)) u_start_pick (
    .sel_i (start_q), .evt_i (evt_i), .hit_o (start_hit)
  );
  perfmon_evt_pick #(.EVT_W(EVT_W)) u_stop_pick (
    .sel_i (stop_q), .evt_i (evt_i), .hit_o (stop_hit)
  );

  perfmon_cyc_cnt #(.HALF_W(DW)) u_cyc (
    .clk         (clk),
    .rst         (rst),
    .en_i        (glob_q & en_q[CYC_IDX]),
    .free_run_i  (start_q == '0),
    .start_hit_i (start_hit),
    .stop_hit_i  (stop_hit),
    .clr_i       (cyc_clr),
    .ld_lo_i     (bus_we_i && bus_addr_i == A_CYC_LO),
    .ld_hi_i     (bus_we_i && bus_addr_i == A_CYC_HI),
    .wdata_i     (bus_wdata_i),
    .cnt_o       (cyc_cnt),
    .wrap_o      (wrap_vec[CYC_IDX])
  );

  // read multiplexer
  always_comb begin
    rd_nxt = '0;
    case (bus_addr_i)
      A_CTRL:              rd_nxt[CTRL_EN] = glob_q;
      A_EN_SET, A_EN_CLR:  rd_nxt = to_bus(en_q);
      A_OV_SET, A_OV_CLR:  rd_nxt = to_bus(ovf_q);
      A_IE_SET, A_IE_CLR:  rd_nxt = to_bus(ien_q);
      A_CYC_LO:            rd_nxt = cyc_cnt[DW-1:0];
      A_CYC_HI:            rd_nxt = cyc_cnt[CYC_W-1:DW];
      A_CYC_CFG: begin
        rd_nxt[START_LSB +: EVT_W] = start_q;
        rd_nxt[STOP_LSB +: EVT_W]  = stop_q;
      end
      default: ;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr_i == ADDR_W'(A_CNT_BASE + i)) rd_nxt = cnt_all[i];
      if (bus_addr_i == ADDR_W'(A_SEL_BASE + i)) rd_nxt[EVT_W-1:0] = sel_all[i];
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we_i && bus_addr_i == A_EN_SET) |=> ((en_q & $past(wmask)) == $past(wmask)));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovf_q & ien_q) != '0) |=> irq_o);

  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i > A_CYC_CFG && bus_addr_i < A_CNT_BASE) |=> bus_rdata_o == '0);

  initial begin
    if (NUM_EVT < 2) $error("event vector too small");
  end
endmodule

// File: tb/perfmon_bank_tb_top.sv
module perfmon_bank_tb_top;
  localparam int NC = 4;
  localparam int EW = 4;
  localparam int NE = 1 << EW;
  localparam bit [31:0] LIVE = 32'h8000_000F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [4:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NE-1:0] evt = '0;
  logic          irq;

  perfmon_bank #(.NUM_CNT(NC), .EVT_W(EW), .DW(32)) dut_i (
    .clk (clk), .rst (rst), .bus_addr_i (addr), .bus_we_i (we),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .evt_i (evt), .irq_o (irq)
  );

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  bit          m_glob;
  bit [31:0]   m_en, m_ovf, m_ien;
  bit [31:0]   m_cnt [NC];
  bit [63:0]   m_cyc;
  bit [EW-1:0] m_sel [NC];
  bit [EW-1:0] m_start, m_stop;
  bit          m_run;
  bit [31:0]   m_rd;
  bit          m_irq;

  function automatic bit hit(input bit [EW-1:0] s);
    if (s == 0) return 1'b0;
    if (s == 1) return 1'b1;
    return evt[s];
  endfunction

  function automatic bit [31:0] rd_model(input bit [4:0] a);
    bit [31:0] r = 0;
    if (a == 0) r[0] = m_glob;
    else if (a == 1 || a == 2) r = m_en;
    else if (a == 3 || a == 4) r = m_ovf;
    else if (a == 5 || a == 6) r = m_ien;
    else if (a == 7) r = m_cyc[31:0];
    else if (a == 8) r = m_cyc[63:32];
    else if (a == 9) r = {12'b0, 4'(m_stop), 12'b0, 4'(m_start)};
    else if (a >= 16 && a < 16 + NC) r = m_cnt[a - 16];
    else if (a >= 24 && a < 24 + NC) r = 32'(m_sel[a - 24]);
    return r;
  endfunction

  function automatic string tag(input bit [4:0] a);
    if (a == 0) return "R2";
    if (a == 1 || a == 2) return "R5";
    if (a == 3 || a == 4) return "R6";
    if (a == 5 || a == 6) return "R7";
    if (a == 7 || a == 8) return "R8/R9";
    if (a == 9) return "R9";
    if (a >= 16 && a < 16 + NC) return "R3";
    if (a >= 24 && a < 24 + NC) return "R4";
    return "R10";
  endfunction

  task automatic model_step();
    bit [31:0] nrd;
    bit        nirq;
    bit [31:0] wr;
    bit        inc [NC];
    bit        ccount, sh, ph;
    if (rst) begin
      m_glob = 0; m_en = 0; m_ovf = 0; m_ien = 0; m_cyc = 0;
      m_start = 0; m_stop = 0; m_run = 0; m_rd = 0; m_irq = 0;
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
      return;
    end
    nrd  = rd_model(addr);
    nirq = |(m_ovf & m_ien);
    wr   = 0;
    for (int i = 0; i < NC; i++) inc[i] = m_glob && m_en[i] && hit(m_sel[i]);
    ccount = m_glob && m_en[31] && (m_start == 0 || m_run);
    sh = hit(m_start);
    ph = hit(m_stop);
    for (int i = 0; i < NC; i++) begin
      if (we && addr == 5'(16 + i)) m_cnt[i] = wdata;
      else if (we && addr == 0 && wdata[1]) m_cnt[i] = 0;
      else if (inc[i]) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wr[i] = 1;
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (we && addr == 7) m_cyc[31:0] = wdata;
    else if (we && addr == 8) m_cyc[63:32] = wdata;
    else if (we && addr == 0 && wdata[2]) m_cyc = 0;
    else if (ccount) begin
      if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) wr[31] = 1;
      m_cyc = m_cyc + 1;
    end
    if (ph) m_run = 0;
    else if (sh) m_run = 1;
    if (we) begin
      case (addr)
        0: m_glob = wdata[0];
        1: m_en  = m_en | (wdata & LIVE);
        2: m_en  = m_en & ~wdata;
        5: m_ien = m_ien | (wdata & LIVE);
        6: m_ien = m_ien & ~wdata;
        9: begin m_start = wdata[EW-1:0]; m_stop = wdata[16 +: EW]; end
        default: ;
      endcase
      for (int i = 0; i < NC; i++) if (addr == 5'(24 + i)) m_sel[i] = wdata[EW-1:0];
    end
    m_ovf = (m_ovf & ~((we && addr == 4) ? wdata : 32'h0))
          | ((we && addr == 3) ? (wdata & LIVE) : 32'h0) | wr;
    m_rd  = nrd;
    m_irq = nirq;
  endtask

  bit [4:0] addr_seen;
  bit       rst_seen;
  always @(posedge clk) begin
    addr_seen = addr;
    rst_seen  = rst;
    model_step();
    #1;
    vectors++;
    if (rdata !== m_rd) begin
      miscompares++;
      $display("FAIL %s rdata addr=0x%02h actual=0x%08h expected=0x%08h",
               rst_seen ? "R1" : tag(addr_seen), addr_seen, rdata, m_rd);
    end
    vectors++;
    if (irq !== m_irq) begin
      miscompares++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", rst_seen ? "R1" : "R7", irq, m_irq);
    end
  end

  task automatic drive(input bit w, input bit [4:0] a, input bit [31:0] d, input bit [NE-1:0] e);
    @(negedge clk);
    we = w; addr = a; wdata = d; evt = e;
  endtask

  task automatic wr_reg(input bit [4:0] a, input bit [31:0] d);
    drive(1'b1, a, d, NE'($urandom));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 5'(k), 32'h0, NE'($urandom));
  endtask

  task automatic quiet(input int n, input bit [NE-1:0] e);
    for (int k = 0; k < n; k++) drive(1'b0, 5'h07, 32'h0, e);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired before the sequence ended");
    finish_run();
  end

  initial begin
    // R1: reset state, swept over every address
    idle(6);
    @(negedge clk); rst = 1'b0;
    idle(34);                                   // R10 unmapped reads included
    // R4: selectors: every cycle, event 5, none, top event 15
    wr_reg(5'h18, 32'd1);
    wr_reg(5'h19, 32'd5);
    wr_reg(5'h1A, 32'd0);
    wr_reg(5'h1B, 32'd15);
    // R5: enable all plus junk bits outside the live set
    wr_reg(5'h01, 32'h8000_00FF);
    idle(40);                                   // R2/R3: global enable off, nothing counts
    wr_reg(5'h00, 32'h1);
    idle(100);                                  // R3/R4: random events
    wr_reg(5'h02, 32'h2);                       // R5: disable counter 1
    idle(30);
    wr_reg(5'h01, 32'h0);                       // R5: zero bits no effect
    wr_reg(5'h02, 32'h0);
    idle(10);
    // R6/R7/R8: preload and wrap
    wr_reg(5'h11, 32'hFFFF_FFF0);
    wr_reg(5'h01, 32'h2);
    wr_reg(5'h10, 32'hFFFF_FFFE);
    wr_reg(5'h05, 32'h1);
    idle(20);
    wr_reg(5'h04, 32'h1);
    idle(6);
    wr_reg(5'h03, 32'h4);                       // R6: set register
    idle(4);
    wr_reg(5'h05, 32'h4);                       // R7
    idle(4);
    wr_reg(5'h06, 32'h5);
    idle(4);
    wr_reg(5'h04, 32'hFFFF_FFFF);
    // R6: wrap and clear in the same cycle, flag stays set
    wr_reg(5'h10, 32'hFFFF_FFFF);
    wr_reg(5'h04, 32'h1);
    idle(6);
    // R8: cycle counter halves and 64-bit wrap
    wr_reg(5'h07, 32'hFFFF_FFF8);
    wr_reg(5'h08, 32'hFFFF_FFFF);
    wr_reg(5'h05, 32'h8000_0000);
    idle(20);
    // R2: counter clears through control
    wr_reg(5'h00, 32'h3);
    idle(6);
    wr_reg(5'h00, 32'h5);
    idle(6);
    // R9: window start 3, stop 4
    wr_reg(5'h09, (32'd4 << 16) | 32'd3);
    quiet(5, 16'h0000);
    quiet(1, 16'h0008);
    quiet(6, 16'h0000);
    quiet(1, 16'h0010);
    quiet(5, 16'h0000);
    quiet(1, 16'h0008);
    quiet(3, 16'h0000);
    quiet(1, 16'h0018);                         // R9: both fire, stop wins
    quiet(5, 16'h0000);
    quiet(1, 16'h0018);
    quiet(5, 16'h0000);
    idle(120);
    wr_reg(5'h09, 32'h0);                       // R9: free run
    idle(20);
    wr_reg(5'h00, 32'h0);                       // R2/R3: global off
    idle(40);
    finish_run();
  end
endmodule